// File: doc/BRIEF.md
# DRAM Window Decoder and Row/Column Address Multiplexer

This block sits between a 24-bit system address bus and an external DRAM. A small control register holds an enable flag and a 4-bit size field. The size field marks a window of 1 MB slices that always ends at the top of the address space. For each bus address the block decides whether the access lands in that window. When it does, the block presents the 10-bit multiplexed memory address on its MA outputs, as either the row half or the column half. A phase input picks the half.

Which address bits go to which MA line depends on the width of the external bus. On a 16-bit bus, address bit 0 carries no information for the word. It is dropped from the row, and bit 16 takes its place on MA0. Accesses outside the window see the low eight address bits passed straight through and the top two MA lines held low. The decision and the MA value are combinational. Only the control register is clocked.

Top module: `dram_window_mux`

## Requirements
- R1: After a synchronous active-low reset the enable flag and the size field are both 0. No address produces a hit, and MA[9:8] read 0.
- R2: When `cfg_we` is high at a rising clock edge, `cfg_wdata[7]` becomes the enable flag and `cfg_wdata[3:0]` becomes the size field, both effective from that edge. Without `cfg_we`, both hold their values.
- R3: Bits 6:4 of `cfg_wdata` are ignored and have no effect on the hit decision or on MA.
- R4: When the enable flag is 0, `dram_hit` is 0 for every address.
- R5: When the size field is 0, `dram_hit` is 0 for every address, even with the enable flag at 1.
- R6: With the enable flag at 1 and size field N in 1..15, `dram_hit` is 1 exactly when `bus_addr[23:20] >= 16 - N`. For example, N=1 covers 0xF00000–0xFFFFFF and N=15 covers 0x100000–0xFFFFFF.
- R7: When `dram_hit` is 0, `ma[7:0]` equals `bus_addr[7:0]` and `ma[9:8]` is 0.
- R8: On a hit with `col_phase`=1, `ma` = {A19, A17, A15..A8}, for either bus width.
- R9: On a hit with `col_phase`=0 and `bus_wide`=0 (8-bit bus), `ma` = {A18, A16, A7..A0}.
- R10: On a hit with `col_phase`=0 and `bus_wide`=1 (16-bit bus), MA0 = A16, MA7..MA1 = A7..A1, MA8 = A18 and MA9 = A20.
- R11: `dram_hit` and `ma` follow `bus_addr`, `bus_wide` and `col_phase` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the control register |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data: bit 7 is the enable flag, bits 3:0 are the size field |
| bus_addr | input | 24 | Current bus address |
| bus_wide | input | 1 | External bus width: 0 = 8-bit, 1 = 16-bit |
| col_phase | input | 1 | MA phase: 0 = row, 1 = column |
| dram_hit | output | 1 | Access falls in the DRAM window |
| ma | output | 10 | Multiplexed memory address |

## Verification
The bench builds the block with its default parameters: a 24-bit address, a 4-bit size field and 8 low MA lines. These values make the whole configuration space small enough to sweep completely. Every value of the enable flag and of the size field is crossed with all sixteen 1 MB slices, both bus widths and both phases. Each combination is tried with several pseudo-random low address patterns. This sweep reaches both edges of the window for every size, including the one-slice and fifteen-slice extremes. It also checks every row and column bit placement against an arithmetic model.

// File: rtl/dmx_pkg.sv
// Package: shared constants and types for the DRAM window decoder.
// Assumes an 8-bit control register with the enable flag at the top bit.
package dmx_pkg;
    localparam int CFG_W  = 8;
    localparam int EN_BIT = 7;

    typedef enum logic { BUS_NARROW = 1'b0, BUS_WIDE = 1'b1 } bus_width_e;
    typedef enum logic { PH_ROW = 1'b0, PH_COL = 1'b1 } ma_phase_e;
endpackage

// File: rtl/dmx_cfg_reg.sv
// Control register: holds the enable flag and the size field.
// Assumes a synchronous active-low reset. Bits between the size field and the
// enable bit are not stored.
module dmx_cfg_reg
    import dmx_pkg::*;
#(
    parameter int AREA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CFG_W-1:0]  wdata,
    output logic              en,
    output logic [AREA_W-1:0] area
);
    // Collect the data bits that are written but never stored.
    logic unused_wbits;
    assign unused_wbits = ^wdata[EN_BIT-1:AREA_W];

    // Capture the enable flag and the size field on a write; clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= 1'b0;
            area <= '0;
        end else if (we) begin
            en   <= wdata[EN_BIT];
            area <= wdata[AREA_W-1:0];
        end
    end

    assert_write_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (en == $past(wdata[EN_BIT])) && (area == $past(wdata[AREA_W-1:0])));
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(en) && $stable(area));
endmodule

// File: rtl/dmx_window_decode.sv
// Window decoder: flags addresses in the top-anchored DRAM window.
// Assumes the window is made of whole slices of 2**(ADDR_W-AREA_W) bytes,
// and that size N covers the N highest slices.
module dmx_window_decode #(
    parameter int ADDR_W = 24,
    parameter int AREA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [AREA_W-1:0] area,
    input  logic [AREA_W-1:0] slice,
    output logic              hit
);
    localparam int CMP_W = AREA_W + 1;
    localparam logic [CMP_W-1:0] SLICES = CMP_W'(1) << AREA_W;

    logic [CMP_W-1:0] first_slice;

    // Compute the lowest slice index inside the window.
    always_comb begin
        first_slice = SLICES - {1'b0, area};
    end

    // Compare the address slice against the window floor.
    always_comb begin
        hit = en && (area != '0) && ({1'b0, slice} >= first_slice);
    end

    assert_no_hit_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !hit);
    assert_no_hit_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (area == '0) |-> !hit);
    assert_top_slice_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && area != '0 && slice == '1) |-> hit);
    assert_bottom_slice_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (slice == '0) |-> !hit);
endmodule

// File: rtl/dmx_addr_mux.sv
// Address multiplexer: builds the row or column MA word.
// Assumes MA has LO_W low lines plus two extra lines. The extra bits come
// from the address bits starting at 2*LO_W. On a wide bus, the row drops
// A0 and carries A(2*LO_W) on MA0.
module dmx_addr_mux
    import dmx_pkg::*;
#(
    parameter int LO_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*LO_W+4:0]   addr,
    input  logic                hit,
    input  logic                wide,
    input  logic                col,
    output logic [LO_W+1:0]     ma
);
    localparam int XB   = 2 * LO_W;
    localparam int MA_W = LO_W + 2;

    logic [MA_W-1:0] row_narrow;
    logic [MA_W-1:0] row_wide;
    logic [MA_W-1:0] col_word;
    logic [MA_W-1:0] pass_word;

    // Build the low lines of each candidate word.
    for (genvar i = 0; i < LO_W; i++) begin : g_lo
        assign row_narrow[i] = addr[i];
        assign col_word[i]   = addr[LO_W + i];
        assign pass_word[i]  = addr[i];
        if (i == 0) begin : g_wide0
            assign row_wide[i] = addr[XB];
        end else begin : g_widen
            assign row_wide[i] = addr[i];
        end
    end

    // Build the two extra lines of each candidate word.
    assign row_narrow[MA_W-1:LO_W] = {addr[XB+2], addr[XB]};
    assign row_wide[MA_W-1:LO_W]   = {addr[XB+4], addr[XB+2]};
    assign col_word[MA_W-1:LO_W]   = {addr[XB+3], addr[XB+1]};
    assign pass_word[MA_W-1:LO_W]  = 2'b00;

    // Select the word for the current access and phase.
    always_comb begin
        if (!hit)
            ma = pass_word;
        else if (ma_phase_e'(col) == PH_COL)
            ma = col_word;
        else if (bus_width_e'(wide) == BUS_WIDE)
            ma = row_wide;
        else
            ma = row_narrow;
    end

    assert_pass_through_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (ma[MA_W-1:LO_W] == 2'b00) && (ma[LO_W-1:0] == addr[LO_W-1:0]));
    assert_col_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && col) |-> (ma[LO_W-1:0] == addr[2*LO_W-1:LO_W]));
    assert_row_narrow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !col && !wide) |-> (ma[LO_W] == addr[XB]));
    assert_row_wide_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !col && wide) |-> (ma[0] == addr[XB]) && (ma[MA_W-1] == addr[XB+4]));
endmodule

// File: rtl/dram_window_mux.sv
// Top: DRAM window decoder and row/column address multiplexer.
// Assumes ADDR_W is wide enough for the extra MA bits (2*LO_W+5 or more).
// Only the control register is clocked; the decode and the MA word are
// combinational.
module dram_window_mux
    import dmx_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int AREA_W = 4,
    parameter int LO_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wide,
    input  logic              col_phase,
    output logic              dram_hit,
    output logic [LO_W+1:0]   ma
);
    localparam int MAP_W     = 2 * LO_W + 5;
    localparam int SLICE_LSB = ADDR_W - AREA_W;

    logic              en_q;
    logic [AREA_W-1:0] area_q;

    // Control register: holds the enable flag and the size field.
    dmx_cfg_reg #(.AREA_W(AREA_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .en    (en_q),
        .area  (area_q)
    );

    // Window decoder: uses the top AREA_W address bits as the slice index.
    dmx_window_decode #(.ADDR_W(ADDR_W), .AREA_W(AREA_W)) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_q),
        .area  (area_q),
        .slice (bus_addr[ADDR_W-1:SLICE_LSB]),
        .hit   (dram_hit)
    );

    // Address multiplexer: only sees the address bits the MA mapping uses.
    dmx_addr_mux #(.LO_W(LO_W)) u_mux (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr[MAP_W-1:0]),
        .hit   (dram_hit),
        .wide  (bus_wide),
        .col   (col_phase),
        .ma    (ma)
    );

    assert_hit_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dram_hit |-> en_q);
endmodule

// File: tb/tb_dram_window_mux.sv
module tb_dram_window_mux;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [7:0]  cfg_wdata;
    logic [23:0] bus_addr;
    logic        bus_wide;
    logic        col_phase;
    logic        dram_hit;
    logic [9:0]  ma;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    dram_window_mux dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .bus_addr(bus_addr), .bus_wide(bus_wide), .col_phase(col_phase),
        .dram_hit(dram_hit), .ma(ma)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h addr=%h", req, act, exp, bus_addr);
        end
    endtask

    task automatic write_cfg(input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_wdata = 8'h00;
    endtask

    function automatic logic model_hit(input logic en, input int area, input logic [23:0] a);
        return en && (area != 0) && (int'(a[23:20]) >= 16 - area);
    endfunction

    function automatic logic [9:0] model_ma(input logic h, input logic w, input logic c,
                                            input logic [23:0] a);
        if (!h) return {2'b00, a[7:0]};
        if (c) return {a[19], a[17], a[15:8]};
        if (w) return {a[20], a[18], a[7:1], a[16]};
        return {a[18], a[16], a[7:0]};
    endfunction

    // Apply one address and check both outputs in the same cycle (R11).
    task automatic probe(input logic en, input int area, input logic [23:0] a,
                         input logic w, input logic c);
        logic eh;
        bus_addr = a; bus_wide = w; col_phase = c;
        #1;
        eh = model_hit(en, area, a);
        if (!en) check("R4", {31'b0, dram_hit}, {31'b0, eh});
        else if (area == 0) check("R5", {31'b0, dram_hit}, {31'b0, eh});
        else check("R6", {31'b0, dram_hit}, {31'b0, eh});
        if (!eh) check("R7", {22'b0, ma}, {22'b0, model_ma(eh, w, c, a)});
        else if (c) check("R8", {22'b0, ma}, {22'b0, model_ma(eh, w, c, a)});
        else if (w) check("R10", {22'b0, ma}, {22'b0, model_ma(eh, w, c, a)});
        else check("R9", {22'b0, ma}, {22'b0, model_ma(eh, w, c, a)});
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = 8'h00;
        bus_addr = 24'hFFFFFF; bus_wide = 1'b0; col_phase = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: after reset, no hit anywhere and the top MA lines are low.
        bus_addr = 24'hFFFFFF; #1;
        check("R1", {31'b0, dram_hit}, 32'd0);
        check("R1", {22'b0, ma}, {22'b0, 10'h0FF});
        // R2: a write without the strobe changes nothing.
        @(negedge clk); cfg_wdata = 8'h8F; @(negedge clk); cfg_wdata = 8'h00; #1;
        check("R2", {31'b0, dram_hit}, 32'd0);
        // R3: bits 6:4 alone do not enable or size the window.
        write_cfg(8'h70); bus_addr = 24'hFA5A5A; #1;
        check("R3", {31'b0, dram_hit}, 32'd0);
        check("R3", {22'b0, ma}, {22'b0, 10'h05A});
        // R3: bits 6:4 set beside a real configuration give the same decode.
        write_cfg(8'hF2); bus_addr = 24'hE12345; #1;
        check("R3", {31'b0, dram_hit}, 32'd1);
        bus_addr = 24'hD12345; #1;
        check("R3", {31'b0, dram_hit}, 32'd0);
        // R2: the new setting is in force right after the write edge.
        write_cfg(8'h81); bus_addr = 24'hF00000; #1;
        check("R2", {31'b0, dram_hit}, 32'd1);
        bus_addr = 24'hEFFFFF; #1;
        check("R2", {31'b0, dram_hit}, 32'd0);

        // Sweep the enable flag, every size, every slice, both widths and both phases.
        for (int en = 0; en < 2; en++) begin
            for (int area = 0; area < 16; area++) begin
                write_cfg({en[0], 3'b000, area[3:0]});
                for (int s = 0; s < 16; s++) begin
                    for (int p = 0; p < 3; p++) begin
                        logic [31:0] mix;
                        mix = (s * 16 + area + p * 977 + en * 31) * 32'h9E3779B1;
                        for (int w = 0; w < 2; w++)
                            for (int c = 0; c < 2; c++)
                                probe(en[0], area, {s[3:0], mix[27:8]}, w[0], c[0]);
                    end
                end
            end
        end

        // R1: a reset clears a live configuration.
        write_cfg(8'h8F);
        @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        bus_addr = 24'hFFFFFF; #1;
        check("R1", {31'b0, dram_hit}, 32'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule